// File: doc/BRIEF.md
# Q15 doubling multiply-accumulate unit

This unit takes two 32-bit source words, picks one signed 16-bit half from each, multiplies the halves and doubles the product. The result is a Q31 value. Three half pairings are available: bottom with bottom, bottom of the first source with top of the second, and top with top. An accumulate variant adds the doubled product to a third 32-bit source and saturates the sum to the signed 32-bit range. The 32-bit result is sign-extended to a 64-bit output word.

Only one doubled product can overflow: -32768 times -32768. The unit treats it as a special case and clamps it to the largest positive value. In accumulate mode, saturation can therefore happen twice in one operation, first on the product and then on the sum. Either clamp sets a sticky saturation flag. The flag stays set until a clear request arrives or reset is applied.

The unit decodes the operation from three instruction fields. An operation is accepted only when the valid strobe is high and the fields form one of the six recognised encodings. By default the result is registered and appears one cycle after the operation is accepted. Reset is asserted asynchronously and released synchronously through a two-stage synchroniser inside the block.

Top module: `q15_dmac`

## Requirements
- R1: An operation is accepted only when `op_valid` is 1, `op_fn_lo` is 3'b001, `op_major` is 7'b1110111 and `op_fn_hi` is one of: 7'b0000101 (bottom×bottom), 7'b0001101 (bottom×top), 7'b0010101 (top×top), 7'b1101001 (accumulate, bottom×bottom), 7'b1110001 (accumulate, bottom×top) or 7'b1111001 (accumulate, top×top). Any other cycle leaves `res_out` and `sat_flag` unchanged.
- R2: Bottom means bits [15:0] and top means bits [31:16]. In the bottom×top pairing, the bottom half is taken from `src_a` and the top half from `src_b`.
- R3: A non-accumulate operation returns twice the signed product of the two selected halves.
- R4: When both selected halves equal -32768, the doubled product is forced to 32'h7FFFFFFF and the saturation flag is set.
- R5: An accumulate operation returns `src_acc` plus the doubled product, clamped to the range [-2^31, 2^31-1]. The flag is set whenever the sum is clamped.
- R6: In accumulate mode, the clamped product from R4 is the value that gets added. A second clamp on the sum still leaves the flag at 1.
- R7: `res_out[63:32]` always equals 32 copies of `res_out[31]`.
- R8: `sat_flag` is sticky. It is set by any clamp in an accepted operation and stays 1 until `sat_clr` is 1. The clear applies to the old value, so a clamp in the same cycle as a clear leaves the flag at 1.
- R9: After reset, `res_out` is 0 and `sat_flag` is 0.
- R10: With `REG_OUT`=1, the result of an accepted operation appears on `res_out` after the next rising clock edge and is held until the next accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_fn_hi | input | 7 | Operation select field |
| op_fn_lo | input | 3 | Operation group field |
| op_major | input | 7 | Major opcode field |
| src_a | input | 32 | First source word (two 16-bit halves) |
| src_b | input | 32 | Second source word (two 16-bit halves) |
| src_acc | input | 32 | Accumulator source word |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| res_out | output | 64 | Sign-extended Q31 result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Some properties are checked by assertions on every cycle:
- The upper half of `res_out` always mirrors bit 31.
- An unaccepted cycle holds both the result and the flag.
- The flag stays set until it is cleared.
- A clear with no accepted operation drops the flag.
- A non-accumulate operation on two -32768 halves yields 32'h7FFFFFFF with the flag raised.

The arithmetic itself can only be shown by the bench scenarios. The bench compares against a 64-bit reference model for each pairing and for corner operands (the positive maximum, its negation, the minimum and zero), with accumulator values at both limits. These scenarios cover correct half selection, the doubling and the two-stage clamping in accumulate mode.

// File: rtl/q15_dmac_pkg.sv
package q15_dmac_pkg;

  localparam int FN_HI_W = 7;
  localparam int FN_LO_W = 3;
  localparam int MAJOR_W = 7;

  localparam logic [MAJOR_W-1:0] MAJOR_CODE = 7'b1110111;
  localparam logic [FN_LO_W-1:0] GROUP_CODE = 3'b001;

  localparam logic [FN_HI_W-1:0] SEL_BB  = 7'b0000101;
  localparam logic [FN_HI_W-1:0] SEL_BT  = 7'b0001101;
  localparam logic [FN_HI_W-1:0] SEL_TT  = 7'b0010101;
  localparam logic [FN_HI_W-1:0] SEL_ABB = 7'b1101001;
  localparam logic [FN_HI_W-1:0] SEL_ABT = 7'b1110001;
  localparam logic [FN_HI_W-1:0] SEL_ATT = 7'b1111001;

  typedef enum logic [1:0] {
    PAIR_BB = 2'd0,
    PAIR_BT = 2'd1,
    PAIR_TT = 2'd2
  } pair_e;

  typedef struct packed {
    logic  hit;
    logic  acc;
    pair_e pair;
  } op_dec_t;

endpackage

// File: rtl/q15_dmac_decode.sv
module q15_dmac_decode
  import q15_dmac_pkg::*;
(
  input  logic               valid_i,
  input  logic [FN_HI_W-1:0] fn_hi_i,
  input  logic [FN_LO_W-1:0] fn_lo_i,
  input  logic [MAJOR_W-1:0] major_i,
  output op_dec_t            dec_o
);

  logic group_ok;

  assign group_ok = valid_i && (fn_lo_i == GROUP_CODE) && (major_i == MAJOR_CODE);

  always_comb begin
    dec_o.hit  = 1'b0;
    dec_o.acc  = 1'b0;
    dec_o.pair = PAIR_BB;
    unique case (fn_hi_i)
      SEL_BB:  begin dec_o.hit = group_ok; dec_o.acc = 1'b0; dec_o.pair = PAIR_BB; end
      SEL_BT:  begin dec_o.hit = group_ok; dec_o.acc = 1'b0; dec_o.pair = PAIR_BT; end
      SEL_TT:  begin dec_o.hit = group_ok; dec_o.acc = 1'b0; dec_o.pair = PAIR_TT; end
      SEL_ABB: begin dec_o.hit = group_ok; dec_o.acc = 1'b1; dec_o.pair = PAIR_BB; end
      SEL_ABT: begin dec_o.hit = group_ok; dec_o.acc = 1'b1; dec_o.pair = PAIR_BT; end
      SEL_ATT: begin dec_o.hit = group_ok; dec_o.acc = 1'b1; dec_o.pair = PAIR_TT; end
      default: begin dec_o.hit = 1'b0;     dec_o.acc = 1'b0; dec_o.pair = PAIR_BB; end
    endcase
  end

endmodule

// File: rtl/q15_dmac_mul.sv
module q15_dmac_mul
  import q15_dmac_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] a_i,
  input  logic [2*HALF_W-1:0] b_i,
  input  pair_e               pair_i,
  output logic [2*HALF_W-1:0] prod_o,
  output logic                clamp_o
);

  localparam int WORD_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] HALF_MIN = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] WORD_MAX = {1'b0, {(WORD_W-1){1'b1}}};

  logic        [HALF_W-1:0] a_half;
  logic        [HALF_W-1:0] b_half;
  logic signed [WORD_W-1:0] raw_prod;
  logic                     both_min;

  // Operand selection: top x top takes both upper halves, otherwise a is low.
  always_comb begin
    a_half = (pair_i == PAIR_TT) ? a_i[WORD_W-1:HALF_W] : a_i[HALF_W-1:0];
    b_half = (pair_i == PAIR_BB) ? b_i[HALF_W-1:0]      : b_i[WORD_W-1:HALF_W];
  end

  assign raw_prod = WORD_W'($signed(a_half)) * WORD_W'($signed(b_half));
  assign both_min = (a_half == HALF_MIN) && (b_half == HALF_MIN);

  // Doubling is a one-bit left shift; only min x min leaves the range.
  always_comb begin
    if (both_min) begin
      prod_o  = WORD_MAX;
      clamp_o = 1'b1;
    end else begin
      prod_o  = {raw_prod[WORD_W-2:0], 1'b0};
      clamp_o = 1'b0;
    end
  end

endmodule

// File: rtl/q15_dmac_acc.sv
module q15_dmac_acc #(
  parameter int WORD_W = 32
) (
  input  logic              en_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] prod_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              clamp_o
);

  localparam logic [WORD_W-1:0] WORD_MAX = {1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [WORD_W-1:0] WORD_MIN = {1'b1, {(WORD_W-1){1'b0}}};

  logic [WORD_W:0] wide_sum;
  logic            ovf;

  assign wide_sum = {acc_i[WORD_W-1], acc_i} + {prod_i[WORD_W-1], prod_i};
  assign ovf      = wide_sum[WORD_W] ^ wide_sum[WORD_W-1];

  always_comb begin
    if (!en_i) begin
      sum_o   = prod_i;
      clamp_o = 1'b0;
    end else if (ovf) begin
      sum_o   = wide_sum[WORD_W] ? WORD_MIN : WORD_MAX;
      clamp_o = 1'b1;
    end else begin
      sum_o   = wide_sum[WORD_W-1:0];
      clamp_o = 1'b0;
    end
  end

endmodule

// File: rtl/q15_dmac.sv
module q15_dmac
  import q15_dmac_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter int OUT_W   = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [FN_HI_W-1:0]    op_fn_hi,
  input  logic [FN_LO_W-1:0]    op_fn_lo,
  input  logic [MAJOR_W-1:0]    op_major,
  input  logic [2*HALF_W-1:0]   src_a,
  input  logic [2*HALF_W-1:0]   src_b,
  input  logic [2*HALF_W-1:0]   src_acc,
  input  logic                  sat_clr,
  output logic [OUT_W-1:0]      res_out,
  output logic                  sat_flag
);

  localparam int WORD_W = 2 * HALF_W;
  localparam int EXT_W  = OUT_W - WORD_W;

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_meta_q;
  logic rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_sync <= rst_meta_q;
    end
  end

  op_dec_t           dec;
  logic [WORD_W-1:0] prod;
  logic              prod_clamp;
  logic [WORD_W-1:0] word_res;
  logic              sum_clamp;
  logic              fire;
  logic [OUT_W-1:0]  res_d;
  logic              sat_d;
  logic              sat_q;

  q15_dmac_decode u_decode (
    .valid_i (op_valid),
    .fn_hi_i (op_fn_hi),
    .fn_lo_i (op_fn_lo),
    .major_i (op_major),
    .dec_o   (dec)
  );

  q15_dmac_mul #(.HALF_W(HALF_W)) u_mul (
    .a_i     (src_a),
    .b_i     (src_b),
    .pair_i  (dec.pair),
    .prod_o  (prod),
    .clamp_o (prod_clamp)
  );

  q15_dmac_acc #(.WORD_W(WORD_W)) u_acc (
    .en_i    (dec.acc),
    .acc_i   (src_acc),
    .prod_i  (prod),
    .sum_o   (word_res),
    .clamp_o (sum_clamp)
  );

  assign fire  = dec.hit;
  assign res_d = {{EXT_W{word_res[WORD_W-1]}}, word_res};

  // Sticky flag next state: clear acts on the old value, new clamps still set.
  always_comb begin
    sat_d = (sat_clr ? 1'b0 : sat_q) | (fire & (prod_clamp | sum_clamp));
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      sat_q <= 1'b0;
    end else begin
      sat_q <= sat_d;
    end
  end

  assign sat_flag = sat_q;

  generate
    if (REG_OUT) begin : g_reg_out
      logic [OUT_W-1:0] res_q;
      always_ff @(posedge clk or negedge rst_n_sync) begin
        if (!rst_n_sync) begin
          res_q <= '0;
        end else if (fire) begin
          res_q <= res_d;
        end
      end
      assign res_out = res_q;
    end else begin : g_comb_out
      assign res_out = fire ? res_d : '0;
    end
  endgenerate

endmodule

// File: rtl/q15_dmac_chk.sv
module q15_dmac_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [6:0]  op_fn_hi,
  input logic [2:0]  op_fn_lo,
  input logic [6:0]  op_major,
  input logic [31:0] src_a,
  input logic [31:0] src_b,
  input logic        sat_clr,
  input logic [63:0] res_out,
  input logic        sat_flag
);

  logic grp_ok;
  logic nacc_hit;
  logic any_hit;
  logic [15:0] ha;
  logic [15:0] hb;

  assign grp_ok   = op_valid && op_fn_lo == 3'b001 && op_major == 7'b1110111;
  assign nacc_hit = grp_ok && (op_fn_hi == 7'b0000101 || op_fn_hi == 7'b0001101 ||
                               op_fn_hi == 7'b0010101);
  assign any_hit  = nacc_hit || (grp_ok && (op_fn_hi == 7'b1101001 ||
                               op_fn_hi == 7'b1110001 || op_fn_hi == 7'b1111001));
  assign ha = (op_fn_hi == 7'b0010101) ? src_a[31:16] : src_a[15:0];
  assign hb = (op_fn_hi == 7'b0000101) ? src_b[15:0]  : src_b[31:16];

  assert_sext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_out[63:32] == {32{res_out[31]}});

  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_hit && !sat_clr) |=> ($stable(res_out) && $stable(sat_flag)));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr && !any_hit) |=> !sat_flag);

  assert_min_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nacc_hit && ha == 16'h8000 && hb == 16'h8000) |=>
      (res_out == 64'h0000_0000_7FFF_FFFF && sat_flag));

endmodule

bind q15_dmac q15_dmac_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .op_valid (op_valid),
  .op_fn_hi (op_fn_hi),
  .op_fn_lo (op_fn_lo),
  .op_major (op_major),
  .src_a    (src_a),
  .src_b    (src_b),
  .sat_clr  (sat_clr),
  .res_out  (res_out),
  .sat_flag (sat_flag)
);

// File: tb/q15_dmac_tb_top.sv
`timescale 1ns/1ps
module q15_dmac_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [6:0]  op_fn_hi = '0;
  logic [2:0]  op_fn_lo = '0;
  logic [6:0]  op_major = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [31:0] src_acc = '0;
  logic        sat_clr = 1'b0;
  logic [63:0] res_out;
  logic        sat_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_flag = 1'b0;

  always #4 clk = ~clk;

  q15_dmac dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_fn_hi(op_fn_hi),
    .op_fn_lo(op_fn_lo), .op_major(op_major), .src_a(src_a), .src_b(src_b),
    .src_acc(src_acc), .sat_clr(sat_clr), .res_out(res_out), .sat_flag(sat_flag)
  );

  localparam logic [6:0] F_BB  = 7'b0000101, F_BT  = 7'b0001101, F_TT  = 7'b0010101;
  localparam logic [6:0] F_ABB = 7'b1101001, F_ABT = 7'b1110001, F_ATT = 7'b1111001;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model in 64-bit arithmetic.
  function automatic longint ref_op(input logic [6:0] f, input logic [31:0] a,
                                    input logic [31:0] b, input logic [31:0] c,
                                    output bit sat);
    longint ah, bh, p, s;
    bit acc;
    acc = f[6];
    ah = (f == F_TT || f == F_ATT) ? longint'($signed(a[31:16])) : longint'($signed(a[15:0]));
    bh = (f == F_BB || f == F_ABB) ? longint'($signed(b[15:0]))  : longint'($signed(b[31:16]));
    p = ah * bh * 2;
    sat = 1'b0;
    if (p > 64'sd2147483647) begin p = 64'sd2147483647; sat = 1'b1; end
    if (!acc) return p;
    s = longint'($signed(c)) + p;
    if (s > 64'sd2147483647) begin s = 64'sd2147483647; sat = 1'b1; end
    if (s < -64'sd2147483648) begin s = -64'sd2147483648; sat = 1'b1; end
    return s;
  endfunction

  task automatic drive(input logic v, input logic [6:0] f, input logic [2:0] f3,
                       input logic [6:0] mj, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c, input logic clr);
    @(negedge clk);
    op_valid = v; op_fn_hi = f; op_fn_lo = f3; op_major = mj;
    src_a = a; src_b = b; src_acc = c; sat_clr = clr;
    @(negedge clk);
    op_valid = 1'b0; sat_clr = 1'b0;
  endtask

  task automatic run_op(input string tag, input logic [6:0] f, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] c);
    bit s;
    longint r;
    r = ref_op(f, a, b, c, s);
    drive(1'b1, f, 3'b001, 7'b1110111, a, b, c, 1'b0);
    exp_flag = exp_flag | s;
    chk(tag, res_out, 64'(r));
    chk({tag, " flag R8"}, {63'd0, sat_flag}, {63'd0, exp_flag});
  endtask

  task automatic clear_flag();
    drive(1'b0, F_BB, 3'b001, 7'b1110111, '0, '0, '0, 1'b1);
    exp_flag = 1'b0;
    chk("R8 clear", {63'd0, sat_flag}, 64'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset result", res_out, 64'd0);
    chk("R9 reset flag", {63'd0, sat_flag}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_flag = 1'b0;
  endtask

  task automatic t_pairs();
    // distinct halves so a wrong pick gives a different product
    run_op("R2 R3 bb", F_BB, {16'd7, 16'd3}, {16'd11, 16'hFFFB}, '0);
    run_op("R2 R3 bt", F_BT, {16'd7, 16'd3}, {16'd11, 16'hFFFB}, '0);
    run_op("R2 R3 tt", F_TT, {16'd7, 16'd3}, {16'd11, 16'hFFFB}, '0);
    run_op("R10 latency", F_TT, {16'h1234, 16'h0}, {16'h0F0F, 16'h0}, '0);
  endtask

  task automatic t_corners();
    logic [15:0] v [4] = '{16'h7FFF, 16'h8001, 16'h8000, 16'h0000};
    for (int m = 0; m < 3; m++) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 4; j++) begin
          logic [6:0] f;
          f = (m == 0) ? F_BB : (m == 1) ? F_BT : F_TT;
          run_op("R3 R4 corner", f, {v[i], v[i]}, {v[j], v[j]}, '0);
        end
        clear_flag();
      end
    end
  endtask

  task automatic t_acc();
    logic [31:0] cv [4] = '{32'h7FFF_FFFF, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF};
    logic [15:0] v [4] = '{16'h7FFF, 16'h8001, 16'h8000, 16'h0000};
    for (int m = 0; m < 3; m++) begin
      for (int k = 0; k < 4; k++) begin
        for (int i = 0; i < 4; i++) begin
          logic [6:0] f;
          f = (m == 0) ? F_ABB : (m == 1) ? F_ABT : F_ATT;
          run_op("R5 R6 acc corner", f, {v[i], v[3-i]}, {v[i], v[i]}, cv[k]);
          clear_flag();
        end
      end
    end
    // product clamp then sum clamp: both in one op
    run_op("R6 double clamp", F_ABB, 32'h0000_8000, 32'h0000_8000, 32'h0000_0001);
    chk("R6 double clamp value", res_out, 64'h0000_0000_7FFF_FFFF);
    clear_flag();
    run_op("R6 product clamp only", F_ABB, 32'h0000_8000, 32'h0000_8000, 32'h8000_0000);
    chk("R6 product clamp value", res_out, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op("R7 negative sext", F_BB, 32'h0000_0002, 32'h0000_FFFD, '0);
    chk("R7 sext value", res_out, 64'hFFFF_FFFF_FFFF_FFF4);
  endtask

  task automatic t_ignored();
    logic [63:0] held;
    clear_flag();
    run_op("R1 setup", F_BB, 32'h0000_0005, 32'h0000_0006, '0);
    held = res_out;
    // saturating operands with a wrong field each time: nothing may change
    drive(1'b1, F_BB, 3'b000, 7'b1110111, 32'h8000_8000, 32'h8000_8000, '0, 1'b0);
    chk("R1 bad group result", res_out, held);
    chk("R1 bad group flag", {63'd0, sat_flag}, 64'd0);
    drive(1'b1, F_BB, 3'b001, 7'b0110011, 32'h8000_8000, 32'h8000_8000, '0, 1'b0);
    chk("R1 bad major result", res_out, held);
    drive(1'b1, 7'b0000100, 3'b001, 7'b1110111, 32'h8000_8000, 32'h8000_8000, '0, 1'b0);
    chk("R1 bad select result", res_out, held);
    drive(1'b0, F_BB, 3'b001, 7'b1110111, 32'h8000_8000, 32'h8000_8000, '0, 1'b0);
    chk("R1 R10 no valid result", res_out, held);
    chk("R1 no valid flag", {63'd0, sat_flag}, 64'd0);
  endtask

  task automatic t_flag();
    run_op("R8 set", F_TT, 32'h8000_0000, 32'h8000_0000, '0);
    drive(1'b0, F_BB, 3'b001, 7'b1110111, '0, '0, '0, 1'b0);
    chk("R8 sticky", {63'd0, sat_flag}, 64'd1);
    drive(1'b1, F_BB, 3'b001, 7'b1110111, 32'h8000, 32'h8000, '0, 1'b1);
    chk("R8 clear with clamp", {63'd0, sat_flag}, 64'd1);
    clear_flag();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_pairs();
    t_corners();
    t_acc();
    t_ignored();
    t_flag();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule